// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block forms the effective address and the writeback pointer for a load or store that uses an address register as its base. The caller presents the register's number, its current contents, a signed element offset, the access width and a flag that selects pre-offset or post-increment use. A mode word and two block-size fields complete the request. The offset is scaled to bytes and added to the pointer.

In linear mode the full-width sum is used. In circular mode only the low N bits of the pointer take part in the arithmetic, and the bits above them are frozen. The pointer therefore wraps inside an aligned block of 2^N bytes, in either direction.

Only registers 4 to 7 on each of the two register sides can be put in circular mode. Each of those eight registers has its own 2-bit field in the mode word, and that field picks linear mode or one of the two block sizes. Results are registered and appear one cycle after the request.

Top module: `cbuf_agen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `out_valid`=0, `eff_addr`=0 and `wb_ptr`=0.
- R2: In linear mode the new pointer is `base_ptr` plus the scaled offset, modulo 2^32, so a sum past the top of the address space wraps to the bottom.
- R3: The offset is sign-extended and then scaled by `acc_size`: code 0 multiplies by 1 (byte), code 1 by 2 (halfword), code 2 by 4 (word), and code 3 is treated like code 2.
- R4: In circular mode with size N, bits N and above of the new pointer equal those of `base_ptr`, and bits N-1..0 equal (base_ptr + scaled offset) mod 2^N.
- R5: A negative offset that carries the pointer below the base of its circular block continues from the top of the same block. In linear mode a negative offset simply subtracts.
- R6: `reg_sel` bit 4 selects the side (0 first, 1 second) and bits 3..0 select the register number. Only register numbers 4..7 are eligible for circular mode; every other register is linear whatever the mode word holds.
- R7: The field for an eligible register is `mode_word[2k+1:2k]`, with k = side*4 + (number-4). Field 00 selects linear mode, 01 selects circular mode with N = `blk_size0`+1, 10 selects circular mode with N = `blk_size1`+1, and 11 selects linear mode.
- R8: With `post_inc`=0 both `eff_addr` and `wb_ptr` are the new pointer. With `post_inc`=1, `eff_addr` is the old `base_ptr` and `wb_ptr` is the new pointer.
- R9: A request with `req_valid`=1 at a clock edge gives `out_valid`=1 and its results after that edge. A cycle with `req_valid`=0 gives `out_valid`=0, and `eff_addr` and `wb_ptr` keep their values.
- R10: A block-size field of 31 gives N=32, so the circular pointer wraps over the whole address space exactly as in linear mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| reg_sel | input | 5 | Base register: side in bit 4, number in bits 3..0 |
| base_ptr | input | 32 | Current contents of the base register |
| offset | input | 16 | Signed offset, counted in elements |
| acc_size | input | 2 | Access width code: 0 byte, 1 half, 2 word, 3 word |
| post_inc | input | 1 | 1 = post-increment, 0 = pre-offset |
| mode_word | input | 16 | Eight 2-bit addressing-mode fields |
| blk_size0 | input | 5 | Block-size field 0, N = value+1 |
| blk_size1 | input | 5 | Block-size field 1, N = value+1 |
| out_valid | output | 1 | Results valid |
| eff_addr | output | 32 | Effective address for the access |
| wb_ptr | output | 32 | Updated pointer for writeback |

## Verification
The bench targets wraps in both directions. It steps upward past the top of a 16-byte block and downward below the base of a 4-byte block, and it moves a negative offset across more than one block length. A design that let the carry or borrow escape into the frozen upper bits would move the pointer into a neighbouring block. The bench also sets circular fields for registers outside 4..7 and fields of neighbouring registers. A decoder that indexed the mode word wrongly would then wrap an address that should be linear. Further cases cover the reserved mode and size codes, the full-width block at size field 31, and post-increment. A design that swapped the old and new pointer would give the wrong effective address while the writeback value stayed correct.

// File: rtl/cbag_pkg.sv
package cbag_pkg;

    localparam int ADDR_W   = 32;
    localparam int OFF_W    = 16;
    localparam int SIDE_REGS = 16;
    localparam int REG_W    = $clog2(SIDE_REGS);
    localparam int SEL_W    = REG_W + 1;
    localparam int CIRC_PER_SIDE = 4;
    localparam int CIRC_FIRST = 4;
    localparam int MFIELD_W = 2;
    localparam int MODE_W   = 2 * CIRC_PER_SIDE * MFIELD_W;
    localparam int SZ_W     = 5;
    localparam int NB_W     = SZ_W + 1;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_e;

    typedef enum logic [MFIELD_W-1:0] {
        MD_LINEAR = 2'd0,
        MD_CIRC0  = 2'd1,
        MD_CIRC1  = 2'd2,
        MD_RSVD   = 2'd3
    } mode_e;

    typedef struct packed {
        logic            circ;
        logic [NB_W-1:0] nbits;
    } wrap_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] eff;
        logic [ADDR_W-1:0] wb;
    } agen_res_t;

    function automatic logic [ADDR_W-1:0] low_mask(input logic [NB_W-1:0] n);
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = (i < int'(n));
        end
        return m;
    endfunction

    function automatic logic [1:0] acc_shift(input acc_e a);
        case (a)
            ACC_BYTE: return 2'd0;
            ACC_HALF: return 2'd1;
            default:  return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/cbag_mode_dec.sv
module cbag_mode_dec
    import cbag_pkg::*;
(
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [MODE_W-1:0] mode_word,
    input  logic [SZ_W-1:0]   blk_size0,
    input  logic [SZ_W-1:0]   blk_size1,
    output wrap_cfg_t         cfg
);
    localparam int POS_W = $clog2(MODE_W);

    logic             side;
    logic [REG_W-1:0] num;
    logic             elig;
    logic [POS_W-1:0] pos;
    mode_e            field;

    always_comb begin
        side  = reg_sel[SEL_W-1];
        num   = reg_sel[REG_W-1:0];
        elig  = (int'(num) >= CIRC_FIRST) && (int'(num) < CIRC_FIRST + CIRC_PER_SIDE);
        pos   = POS_W'({side, num[1:0]}) * POS_W'(MFIELD_W);
        field = mode_e'(mode_word[pos +: MFIELD_W]);
        cfg.circ  = 1'b0;
        cfg.nbits = NB_W'(ADDR_W);
        if (elig) begin
            case (field)
                MD_CIRC0: begin
                    cfg.circ  = 1'b1;
                    cfg.nbits = NB_W'(blk_size0) + NB_W'(1);
                end
                MD_CIRC1: begin
                    cfg.circ  = 1'b1;
                    cfg.nbits = NB_W'(blk_size1) + NB_W'(1);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cbag_offset_scale.sv
module cbag_offset_scale
    import cbag_pkg::*;
(
    input  logic [OFF_W-1:0]  offset,
    input  acc_e              acc,
    output logic [ADDR_W-1:0] scaled
);
    logic [ADDR_W-1:0] ext;

    always_comb begin
        ext    = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        scaled = ext << acc_shift(acc);
    end
endmodule

// File: rtl/cbag_wrap_add.sv
module cbag_wrap_add
    import cbag_pkg::*;
(
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] scaled,
    input  wrap_cfg_t         cfg,
    input  logic              post,
    output agen_res_t         res
);
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] nxt;

    always_comb begin
        sum  = ptr + scaled;
        mask = cfg.circ ? low_mask(cfg.nbits) : '1;
        nxt  = (ptr & ~mask) | (sum & mask);
        res.wb  = nxt;
        res.eff = post ? ptr : nxt;
    end
endmodule

// File: rtl/cbuf_agen.sv
module cbuf_agen
    import cbag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [4:0]        reg_sel,
    input  logic [31:0]       base_ptr,
    input  logic [15:0]       offset,
    input  logic [1:0]        acc_size,
    input  logic              post_inc,
    input  logic [15:0]       mode_word,
    input  logic [4:0]        blk_size0,
    input  logic [4:0]        blk_size1,
    output logic              out_valid,
    output logic [31:0]       eff_addr,
    output logic [31:0]       wb_ptr
);
    wrap_cfg_t         cfg;
    logic [ADDR_W-1:0] scaled;
    agen_res_t         res;
    logic              circ_en;
    logic [NB_W-1:0]   circ_nbits;

    cbag_mode_dec i_dec (
        .reg_sel   (reg_sel),
        .mode_word (mode_word),
        .blk_size0 (blk_size0),
        .blk_size1 (blk_size1),
        .cfg       (cfg)
    );

    cbag_offset_scale i_scale (
        .offset (offset),
        .acc    (acc_e'(acc_size)),
        .scaled (scaled)
    );

    cbag_wrap_add i_add (
        .ptr    (base_ptr),
        .scaled (scaled),
        .cfg    (cfg),
        .post   (post_inc),
        .res    (res)
    );

    assign circ_en    = cfg.circ;
    assign circ_nbits = cfg.nbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            eff_addr  <= '0;
            wb_ptr    <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                eff_addr <= res.eff;
                wb_ptr   <= res.wb;
            end
        end
    end
endmodule

// File: rtl/cbuf_agen_chk.sv
module cbuf_agen_chk
    import cbag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              post_inc,
    input logic [ADDR_W-1:0] base_ptr,
    input logic              circ_en,
    input logic [NB_W-1:0]   circ_nbits,
    input logic              out_valid,
    input logic [ADDR_W-1:0] eff_addr,
    input logic [ADDR_W-1:0] wb_ptr
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && eff_addr == '0 && wb_ptr == '0));

    p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && $stable(eff_addr) && $stable(wb_ptr)));

    p_post_old_ptr_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && post_inc) |=> (eff_addr == $past(base_ptr)));

    p_pre_same_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !post_inc) |=> (eff_addr == wb_ptr));

    p_upper_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && circ_en && int'(circ_nbits) < ADDR_W)
        |=> (((wb_ptr ^ $past(base_ptr)) >> $past(circ_nbits)) == '0));
endmodule

bind cbuf_agen cbuf_agen_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .post_inc   (post_inc),
    .base_ptr   (base_ptr),
    .circ_en    (circ_en),
    .circ_nbits (circ_nbits),
    .out_valid  (out_valid),
    .eff_addr   (eff_addr),
    .wb_ptr     (wb_ptr)
);

// File: tb/test_cbuf_agen.sv
module test_cbuf_agen;

    typedef struct packed {
        logic [4:0]  sel;
        logic [15:0] mode;
        logic [4:0]  sz0;
        logic [4:0]  sz1;
        logic [1:0]  acc;
        logic        post;
        logic [31:0] ptr;
        logic [15:0] off;
        logic [31:0] exp_eff;
        logic [31:0] exp_wb;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        // R2 linear word step
        '{5'd4,  16'h0000, 5'd3, 5'd0, 2'd2, 1'b0, 32'h0000_1000, 16'h0003, 32'h0000_100C, 32'h0000_100C, 8'd2},
        // R3 byte
        '{5'd1,  16'h0000, 5'd0, 5'd0, 2'd0, 1'b0, 32'h0000_2000, 16'h0005, 32'h0000_2005, 32'h0000_2005, 8'd3},
        // R3 halfword
        '{5'd1,  16'h0000, 5'd0, 5'd0, 2'd1, 1'b0, 32'h0000_2000, 16'h0005, 32'h0000_200A, 32'h0000_200A, 8'd3},
        // R3 code 3 acts as word
        '{5'd1,  16'h0000, 5'd0, 5'd0, 2'd3, 1'b0, 32'h0000_2000, 16'h0005, 32'h0000_2014, 32'h0000_2014, 8'd3},
        // R4 upward wrap in 16-byte block (first side reg 5, field 01)
        '{5'd5,  16'h0004, 5'd3, 5'd0, 2'd0, 1'b0, 32'h8000_000C, 16'h0006, 32'h8000_0002, 32'h8000_0002, 8'd4},
        // R5 negative wrap below base
        '{5'd5,  16'h0004, 5'd3, 5'd0, 2'd0, 1'b0, 32'h8000_0002, 16'hFFFC, 32'h8000_000E, 32'h8000_000E, 8'd5},
        // R8 post-increment with wrap
        '{5'd5,  16'h0004, 5'd3, 5'd0, 2'd2, 1'b1, 32'h8000_000E, 16'h0001, 32'h8000_000E, 32'h8000_0002, 8'd8},
        // R7 field 10 picks size field 1 (second side reg 6)
        '{5'd22, 16'h2000, 5'd3, 5'd7, 2'd2, 1'b0, 32'h0001_23F0, 16'h0008, 32'h0001_2310, 32'h0001_2310, 8'd7},
        // R7 field 11 is linear
        '{5'd22, 16'h3000, 5'd3, 5'd7, 2'd2, 1'b0, 32'h0001_23F0, 16'h0008, 32'h0001_2410, 32'h0001_2410, 8'd7},
        // R6 register 3 never circular
        '{5'd3,  16'h5555, 5'd3, 5'd3, 2'd0, 1'b0, 32'h8000_000C, 16'h0006, 32'h8000_0012, 32'h8000_0012, 8'd6},
        // R6 register 8 never circular
        '{5'd8,  16'h5555, 5'd3, 5'd3, 2'd0, 1'b0, 32'h8000_000C, 16'h0006, 32'h8000_0012, 32'h8000_0012, 8'd6},
        // R6 second side register 3 never circular
        '{5'd19, 16'h5555, 5'd3, 5'd3, 2'd0, 1'b0, 32'h8000_000C, 16'h0006, 32'h8000_0012, 32'h8000_0012, 8'd6},
        // R7 neighbour field set, own field linear
        '{5'd4,  16'h0004, 5'd3, 5'd3, 2'd0, 1'b0, 32'h8000_000C, 16'h0006, 32'h8000_0012, 32'h8000_0012, 8'd7},
        // R10 size field 31 wraps full width
        '{5'd4,  16'h0001, 5'd31, 5'd0, 2'd2, 1'b0, 32'hFFFF_FFFC, 16'h0002, 32'h0000_0004, 32'h0000_0004, 8'd10},
        // R5 negative post-increment in 4-byte block (second side reg 4)
        '{5'd20, 16'h0100, 5'd1, 5'd0, 2'd1, 1'b1, 32'h0000_1001, 16'hFFFF, 32'h0000_1001, 32'h0000_1003, 8'd5},
        // R4 negative move spanning several blocks (first side reg 7, field 10)
        '{5'd7,  16'h0080, 5'd0, 5'd3, 2'd0, 1'b0, 32'h0000_0A05, 16'hFFD8, 32'h0000_0A0D, 32'h0000_0A0D, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [4:0]  reg_sel;
    logic [31:0] base_ptr;
    logic [15:0] offset;
    logic [1:0]  acc_size;
    logic        post_inc;
    logic [15:0] mode_word;
    logic [4:0]  blk_size0;
    logic [4:0]  blk_size1;
    logic        out_valid;
    logic [31:0] eff_addr;
    logic [31:0] wb_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cbuf_agen i_cbuf_agen (
        .clk(clk), .rst(rst), .req_valid(req_valid), .reg_sel(reg_sel),
        .base_ptr(base_ptr), .offset(offset), .acc_size(acc_size),
        .post_inc(post_inc), .mode_word(mode_word), .blk_size0(blk_size0),
        .blk_size1(blk_size1), .out_valid(out_valid), .eff_addr(eff_addr),
        .wb_ptr(wb_ptr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        reg_sel   = v.sel;
        mode_word = v.mode;
        blk_size0 = v.sz0;
        blk_size1 = v.sz1;
        acc_size  = v.acc;
        post_inc  = v.post;
        base_ptr  = v.ptr;
        offset    = v.off;
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; reg_sel = '0; base_ptr = '0; offset = '0;
        acc_size = '0; post_inc = 1'b0; mode_word = '0; blk_size0 = '0; blk_size1 = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 eff_addr", eff_addr, 32'd0);
        check("R1 wb_ptr", wb_ptr, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            req_valid = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vec%0d eff", VECS[i].req, i), eff_addr, VECS[i].exp_eff);
            check($sformatf("R%0d vec%0d wb", VECS[i].req, i), wb_ptr, VECS[i].exp_wb);
            check($sformatf("R9 vec%0d valid", i), {31'd0, out_valid}, 32'd1);
        end

        // R9 idle cycle: changed inputs must not move outputs
        req_valid = 1'b0;
        base_ptr  = 32'h1234_5678;
        offset    = 16'h0010;
        @(negedge clk);
        check("R9 idle valid", {31'd0, out_valid}, 32'd0);
        check("R9 idle eff hold", eff_addr, VECS[NV-1].exp_eff);
        check("R9 idle wb hold", wb_ptr, VECS[NV-1].exp_wb);

        // R1 reset after activity
        rst = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset wb", wb_ptr, 32'd0);
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule